// File: doc/BRIEF.md
# TDM Audio Serial Data Port

This block moves audio sample words between a parallel interface and a time-division-multiplexed serial link. A frame holds one to eight channel slots. Every slot is 32 bit-clock periods long, and slots run in ascending channel order from channel 0. An external master supplies the bit clock and the frame sync. The block oversamples both on its own system clock, detects their edges, and runs a slot and bit pointer that restarts on every rising edge of frame sync.

On the transmit side, one holding register takes a right-adjusted word through a valid/ready handshake. It also reports the channel that word will fill. At the start of each slot the word is placed MSB first at the top of the slot, and the slot bits after it are zero. If the holding register is empty when the slot starts, the slot is sent as zeros and an underrun pulse is raised.

On the receive side, the first word-length bits of each slot are collected into a right-adjusted word. The rest of the slot is ignored. The finished word is presented with a one-cycle valid strobe and its channel number.

Top module: `tdm_serial_port`

## Requirements
- R1: The slot count per frame is `chanCountM1`+1, from 1 to 8. Received words are reported once per slot in ascending channel order 0, 1, …, with `rxChan` giving the slot index.
- R2: A frame starts at the first bit-clock rising edge where frame sync is sampled high after having been sampled low. The MSB of channel 0 occupies the next bit period, and every slot lasts 32 bit periods.
- R3: `sdOut` changes only in response to a bit-clock falling edge. `sdIn` is sampled in response to a bit-clock rising edge.
- R4: `wordLenSel` sets the word length as follows: 0 gives 8 bits, 1 gives 16, 2 gives 18, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32.
- R5: Transmit sends bits L-1 down to 0 of the held word in the first L slot bits, MSB first. The remaining slot bits are zero, and bits of `txData` above L-1 are never sent.
- R6: Receive places the first L bits of a slot right-adjusted in `rxData`, first bit most significant. Bits above L-1 are zero, and later slot bits are discarded.
- R7: If the holding register is empty when a slot starts, the whole slot is sent as zeros and `txUnderrun` pulses for one cycle.
- R8: A new frame-sync rising edge in mid-frame restarts the pointer at channel 0. The unfinished receive slot is never reported.
- R9: `rxValid` is a single-cycle pulse, raised once the last bit of its slot has been sampled.
- R10: A word is accepted when `txValid` and `txReady` are both high, after which `txReady` falls until a slot start takes the word. `txChan` names the slot the held word will fill.
- R11: After reset, `sdOut`, `rxValid` and `txUnderrun` are low, `txReady` is high and `txChan` is 0.
- R12: From the end of the last slot until the next frame-sync edge, `sdOut` is low and no received word is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Serial bit clock from the link master |
| fsIn | input | 1 | Frame sync from the link master |
| sdIn | input | 1 | Serial receive data |
| chanCountM1 | input | CH_W | Slot count per frame minus one |
| wordLenSel | input | 3 | Word length select (see R4) |
| txData | input | SLOT_BITS | Right-adjusted transmit word |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Holding register empty; requests next word |
| txChan | output | CH_W | Channel the held or next word will fill |
| txUnderrun | output | 1 | One-cycle pulse when a slot starts with no word |
| sdOut | output | 1 | Serial transmit data |
| rxData | output | SLOT_BITS | Right-adjusted received word |
| rxValid | output | 1 | One-cycle strobe for a received word |
| rxChan | output | CH_W | Channel of the received word |

## Verification
The bench builds the block with its defaults: eight channels at most and 32-bit slots. With these, every word-length code can be tried, including the full-slot 32-bit case where nothing is padded or discarded, as well as the two unused codes. They also allow frames of one channel and of all eight. Frames use both a one-period sync pulse and a slot-wide sync, and include an underrun in a middle slot and a restart in mid-frame. Randomised frames mix channel count, word length and underrun position.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Strobes from the link control to the datapath, one cycle each.
  typedef struct packed {
    logic frameStart;  // frame-sync edge seen at a rising bit-clock edge
    logic txLoad;      // falling edge at bit 0 of a slot: load new word
    logic txAdvance;   // falling edge inside a frame: present next bit
    logic txIdle;      // falling edge outside a frame: drive zero
    logic rxSample;    // rising edge inside a frame: sample one bit
    logic rxUse;       // sampled bit lies within the word length
    logic rxFirst;     // sampled bit is the first of its slot
    logic rxLast;      // sampled bit is the last of its slot
  } tdmStrobes_t;

  // Word length in bits for each select code.
  function automatic logic [5:0] decodeLen(input logic [2:0] sel);
    case (sel)
      3'd0:    return 6'd8;
      3'd1:    return 6'd16;
      3'd2:    return 6'd18;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_link_ctrl.sv
module tdm_link_ctrl
  import tdm_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int SLOT_BITS = 32,
  parameter int LEN_W     = $clog2(SLOT_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckIn,
  input  logic                fsIn,
  input  logic                sdIn,
  input  logic [CH_W-1:0]     chanCountM1,
  input  logic [LEN_W-1:0]    wordLen,
  output tdmStrobes_t         strobes,
  output logic [CH_W-1:0]     chan,
  output logic                sdSample
);

  localparam int BIT_W = $clog2(SLOT_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

  logic sckQ, sckPrev, fsQ, sdQ, fsAtRise;
  logic running;
  logic [BIT_W-1:0] posBit;
  logic [CH_W-1:0]  posChan;

  logic sckRise, sckFall, fsEdge, lastBit, lastChan;

  assign sckRise  = sckQ & ~sckPrev;
  assign sckFall  = ~sckQ & sckPrev;
  assign fsEdge   = sckRise & fsQ & ~fsAtRise;
  assign lastBit  = (posBit == LAST_BIT);
  assign lastChan = (posChan >= chanCountM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      sckPrev  <= 1'b0;
      fsQ      <= 1'b0;
      sdQ      <= 1'b0;
      fsAtRise <= 1'b0;
      running  <= 1'b0;
      posBit   <= '0;
      posChan  <= '0;
    end else begin
      sckQ    <= sckIn;
      sckPrev <= sckQ;
      fsQ     <= fsIn;
      sdQ     <= sdIn;
      if (sckRise) begin
        fsAtRise <= fsQ;
        if (fsEdge) begin
          running <= 1'b1;
          posBit  <= '0;
          posChan <= '0;
        end else if (running) begin
          if (lastBit) begin
            posBit <= '0;
            if (lastChan) running <= 1'b0;
            else          posChan <= posChan + 1'b1;
          end else begin
            posBit <= posBit + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.frameStart = fsEdge;
    strobes.rxSample   = sckRise & ~fsEdge & running;
    strobes.rxUse      = int'(posBit) < int'(wordLen);
    strobes.rxFirst    = (posBit == '0);
    strobes.rxLast     = lastBit;
    strobes.txLoad     = sckFall & running & (posBit == '0);
    strobes.txAdvance  = sckFall & running;
    strobes.txIdle     = sckFall & ~running;
  end

  assign chan     = posChan;
  assign sdSample = sdQ;

endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int SLOT_BITS = 32,
  parameter int LEN_W     = $clog2(SLOT_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tdmStrobes_t          strobes,
  input  logic [CH_W-1:0]      chan,
  input  logic                 sdSample,
  input  logic [CH_W-1:0]      chanCountM1,
  input  logic [LEN_W-1:0]     wordLen,
  input  logic [SLOT_BITS-1:0] txData,
  input  logic                 txValid,
  output logic                 txReady,
  output logic [CH_W-1:0]      txChan,
  output logic                 txUnderrun,
  output logic                 sdOut,
  output logic [SLOT_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic [CH_W-1:0]      rxChan
);

  localparam int MSB = SLOT_BITS - 1;

  logic [SLOT_BITS-1:0] txHold, txShift, aligned;
  logic                 txFull, sdOutR, underrunR;
  logic [CH_W-1:0]      nextChan;
  logic [SLOT_BITS-1:0] rxShift, rxBase, rxNext, rxDataR;
  logic                 rxValidR;
  logic [CH_W-1:0]      rxChanR;

  // Left-adjust the low wordLen bits of the held word; the rest stays zero.
  always_comb begin
    aligned = '0;
    for (int i = 0; i < SLOT_BITS; i++) begin
      if (i < int'(wordLen)) aligned[MSB-i] = txHold[int'(wordLen) - 1 - i];
    end
  end

  // Receive shift: clear at slot start, shift in only bits inside the word.
  always_comb begin
    rxBase = strobes.rxFirst ? '0 : rxShift;
    rxNext = strobes.rxUse ? {rxBase[MSB-1:0], sdSample} : rxBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold    <= '0;
      txFull    <= 1'b0;
      txShift   <= '0;
      sdOutR    <= 1'b0;
      underrunR <= 1'b0;
      nextChan  <= '0;
      rxShift   <= '0;
      rxDataR   <= '0;
      rxValidR  <= 1'b0;
      rxChanR   <= '0;
    end else begin
      underrunR <= 1'b0;
      rxValidR  <= 1'b0;

      if (txValid && !txFull) begin
        txHold <= txData;
        txFull <= 1'b1;
      end

      if (strobes.frameStart) nextChan <= '0;

      if (strobes.txLoad) begin
        if (txFull) begin
          sdOutR  <= aligned[MSB];
          txShift <= aligned << 1;
          txFull  <= 1'b0;
        end else begin
          sdOutR    <= 1'b0;
          txShift   <= '0;
          underrunR <= 1'b1;
        end
        nextChan <= (chan >= chanCountM1) ? '0 : chan + 1'b1;
      end else if (strobes.txAdvance) begin
        sdOutR  <= txShift[MSB];
        txShift <= txShift << 1;
      end else if (strobes.txIdle) begin
        sdOutR <= 1'b0;
      end

      if (strobes.rxSample) begin
        rxShift <= rxNext;
        if (strobes.rxLast) begin
          rxDataR  <= rxNext;
          rxValidR <= 1'b1;
          rxChanR  <= chan;
        end
      end
    end
  end

  assign txReady    = ~txFull;
  assign txChan     = nextChan;
  assign txUnderrun = underrunR;
  assign sdOut      = sdOutR;
  assign rxData     = rxDataR;
  assign rxValid    = rxValidR;
  assign rxChan     = rxChanR;

endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
  import tdm_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckIn,
  input  logic                 fsIn,
  input  logic                 sdIn,
  input  logic [CH_W-1:0]      chanCountM1,
  input  logic [2:0]           wordLenSel,
  input  logic [SLOT_BITS-1:0] txData,
  input  logic                 txValid,
  output logic                 txReady,
  output logic [CH_W-1:0]      txChan,
  output logic                 txUnderrun,
  output logic                 sdOut,
  output logic [SLOT_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic [CH_W-1:0]      rxChan
);

  localparam int LEN_W = $clog2(SLOT_BITS + 1);

  logic [LEN_W-1:0] decoded, wordLen;
  tdmStrobes_t      strobes;
  logic [CH_W-1:0]  chan;
  logic             sdSample;

  assign decoded = LEN_W'(decodeLen(wordLenSel));
  assign wordLen = (int'(decoded) > SLOT_BITS) ? LEN_W'(SLOT_BITS) : decoded;

  tdm_link_ctrl #(.CH_W(CH_W), .SLOT_BITS(SLOT_BITS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .fsIn(fsIn), .sdIn(sdIn),
    .chanCountM1(chanCountM1), .wordLen(wordLen),
    .strobes(strobes), .chan(chan), .sdSample(sdSample)
  );

  tdm_datapath #(.CH_W(CH_W), .SLOT_BITS(SLOT_BITS), .LEN_W(LEN_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chan(chan),
    .sdSample(sdSample), .chanCountM1(chanCountM1), .wordLen(wordLen),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .txChan(txChan), .txUnderrun(txUnderrun), .sdOut(sdOut),
    .rxData(rxData), .rxValid(rxValid), .rxChan(rxChan)
  );

endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
  parameter int CH_W      = 3,
  parameter int SLOT_BITS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CH_W-1:0]      chanCountM1,
  input logic [2:0]           wordLenSel,
  input logic                 txValid,
  input logic                 txReady,
  input logic [CH_W-1:0]      txChan,
  input logic                 txUnderrun,
  input logic                 sdOut,
  input logic [SLOT_BITS-1:0] rxData,
  input logic                 rxValid,
  input logic [CH_W-1:0]      rxChan
);

  logic [5:0] lenNow;
  assign lenNow = tdm_pkg::decodeLen(wordLenSel);

  // R9
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> !sdOut);

  // R10
  accept_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R1
  rx_chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (rxChan <= chanCountM1));

  // R10
  tx_chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    txChan <= chanCountM1);

  // R6
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> lenNow) == '0));

endmodule

bind tdm_serial_port tdm_serial_port_chk #(.CH_W(CH_W), .SLOT_BITS(SLOT_BITS)) u_chk (.*);

// File: tb/tdm_serial_port_bench.sv
module tdm_serial_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;   // system clocks per bit-clock half period
  localparam int NONE       = 99;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sckIn = 1'b1, fsIn = 1'b0, sdIn = 1'b0;
  logic [2:0]  chanCountM1 = '0;
  logic [2:0]  wordLenSel = '0;
  logic [31:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady, txUnderrun, sdOut, rxValid;
  logic [2:0]  txChan, rxChan;
  logic [31:0] rxData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_serial_port u_tdm_serial_port (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .fsIn(fsIn), .sdIn(sdIn),
    .chanCountM1(chanCountM1), .wordLenSel(wordLenSel),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .txChan(txChan), .txUnderrun(txUnderrun), .sdOut(sdOut),
    .rxData(rxData), .rxValid(rxValid), .rxChan(rxChan)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input int sel);
    case (sel)
      0: return 8;
      1: return 16;
      2: return 18;
      3: return 20;
      4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] txExpect(input logic [31:0] w, input int len);
    logic [63:0] m;
    m = {32'd0, w} & ((64'd1 << len) - 64'd1);
    return 32'(m << (32 - len));
  endfunction

  function automatic logic [31:0] rxExpect(input logic [31:0] slot, input int len);
    return slot >> (32 - len);
  endfunction

  // Word feeder: refills the holding register except for the channel to starve.
  bit          feedOn = 0;
  int          skipCh = NONE;
  logic [31:0] lastFed = '0;
  always @(negedge clk) begin
    if (feedOn && txReady && int'(txChan) != skipCh) begin
      txData  = $urandom;
      txValid = 1'b1;
      lastFed = txData;
    end else begin
      txValid = 1'b0;
    end
  end

  // Receive and underrun monitor.
  int          rxCnt = 0, urCnt = 0;
  logic [31:0] gotData [8];
  logic [2:0]  gotChan [8];
  always @(negedge clk) begin
    if (rxValid) begin
      if (rxCnt < 8) begin
        gotData[rxCnt] = rxData;
        gotChan[rxCnt] = rxChan;
      end
      rxCnt++;
    end
    if (txUnderrun) urCnt++;
  end

  // One bit period: falling edge with new fs/sd, sample sdOut, rising edge.
  task automatic bitPeriod(input logic fsVal, input logic sdVal, output logic txBit);
    @(negedge clk);
    sckIn = 1'b0; fsIn = fsVal; sdIn = sdVal;
    repeat (HALF_BIT - 1) @(negedge clk);
    txBit = sdOut;
    @(negedge clk);
    sckIn = 1'b1;
    repeat (HALF_BIT - 1) @(negedge clk);
  endtask

  task automatic runFrame(input int n, input int sel, input int skip,
                          input bit fsWide, input int abortBits, input bit checkIdle);
    logic [31:0] slots [8];
    logic [31:0] txGot, slotExp;
    logic        b;
    int          len;
    len = lenOf(sel);
    for (int c = 0; c < 8; c++) slots[c] = $urandom;
    chanCountM1 = 3'(n - 1);
    wordLenSel  = 3'(sel);
    skipCh      = skip;
    rxCnt = 0; urCnt = 0;
    txGot = '0; slotExp = '0;
    for (int k = 0; k < 2; k++) begin
      bitPeriod(1'b0, 1'($urandom), b);
      // R12: outside a frame the line stays low
      if (checkIdle) check(b == 1'b0, "R12 idle sdOut", 64'(b), 64'd0);
    end
    if (checkIdle) check(rxCnt == 0, "R12 no rx while idle", 64'(rxCnt), 64'd0);
    bitPeriod(1'b1, 1'($urandom), b);
    for (int bi = 0; bi < 32 * n; bi++) begin
      int ch, k;
      ch = bi / 32;
      k  = bi % 32;
      if (k == 0) slotExp = (ch == skip) ? 32'd0 : txExpect(lastFed, len);
      bitPeriod(fsWide && bi < 31, slots[ch][31-k], b);
      txGot[31-k] = b;
      if (k == 31) begin
        // R2 R5 R3: slot carries the word MSB first from the bit after sync
        check(txGot == slotExp, (len == 32) ? "R2 tx full slot" : "R5 tx padded slot",
              64'(txGot), 64'(slotExp));
      end
      if (abortBits > 0 && bi == abortBits - 1) return;
    end
    repeat (4) @(negedge clk);
    // R1: one word per slot, in ascending channel order
    check(rxCnt == n, "R1 rx word count", 64'(rxCnt), 64'(n));
    for (int c = 0; c < n && c < rxCnt; c++) begin
      check(int'(gotChan[c]) == c, "R1 rx channel order", 64'(gotChan[c]), 64'(c));
      // R6 R4: first L bits of the slot, right-adjusted
      check(gotData[c] == rxExpect(slots[c], len), "R6 rx word",
            64'(gotData[c]), 64'(rxExpect(slots[c], len)));
    end
    // R7: one underrun pulse only for the starved slot
    check(urCnt == ((skip < n) ? 1 : 0), "R7 underrun count", 64'(urCnt),
          64'((skip < n) ? 1 : 0));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(sdOut == 1'b0, "R11 sdOut", 64'(sdOut), 64'd0);
    check(rxValid == 1'b0, "R11 rxValid", 64'(rxValid), 64'd0);
    check(txReady == 1'b1, "R11 txReady", 64'(txReady), 64'd1);
    check(txChan == 3'd0, "R11 txChan", 64'(txChan), 64'd0);
    check(txUnderrun == 1'b0, "R11 txUnderrun", 64'(txUnderrun), 64'd0);
    feedOn = 1;
    repeat (3) @(negedge clk);
    // R10: accepted word drops ready; it is destined for channel 0
    check(txReady == 1'b0, "R10 ready after accept", 64'(txReady), 64'd0);
    check(txChan == 3'd0, "R10 txChan before frame", 64'(txChan), 64'd0);

    runFrame(8, 5, NONE, 0, 0, 1);   // R4 32-bit, eight channels
    runFrame(1, 0, NONE, 0, 0, 1);   // R4 8-bit, single channel
    runFrame(4, 2, NONE, 0, 0, 1);   // R4 18-bit
    runFrame(3, 3, 1,    0, 0, 1);   // R7 underrun in middle slot, 20-bit
    runFrame(2, 4, NONE, 1, 0, 1);   // R2 slot-wide sync, 24-bit
    runFrame(5, 1, NONE, 0, 0, 1);   // R4 16-bit
    runFrame(3, 6, NONE, 0, 0, 1);   // R4 spare code means 32-bit
    runFrame(4, 1, NONE, 0, 42, 1);  // R8 abort inside channel 1
    // R8: only channel 0 completed before the restart
    check(rxCnt == 1, "R8 words before restart", 64'(rxCnt), 64'd1);
    runFrame(4, 1, NONE, 0, 0, 0);   // R8 restart at channel 0, no stale word
    for (int r = 0; r < 6; r++) begin
      int n, sel, sk;
      n   = 1 + int'($urandom % 8);
      sel = int'($urandom % 8);
      sk  = (n > 1 && ($urandom % 2) == 1) ? 1 + int'($urandom % (n - 1)) : NONE;
      runFrame(n, sel, sk, 1'($urandom % 2), 0, 1);
    end
    // R9: the checker watches pulse width; here the last word has settled
    check(rxValid == 1'b0, "R9 rxValid drops", 64'(rxValid), 64'd0);
    finish();
  end

endmodule